// File: doc/BRIEF.md
# Pressed-Key Set Event Filter

This block sits behind a matrix-keyboard scanner. Each snapshot it receives holds up to eight packed key entries and a count of valid entries. The block turns each snapshot into a list of pressed scan codes. It then compares that list with the list it accepted last time and sends key events downstream.

When function-key mapping is on, any entry that equals the configured function-key code is left out of the list. The other codes are then moved into an alternate bank. The block can also reject a whole snapshot that looks like ghosting: three or more keys where some pair shares a row and some pair shares a column. A rejected snapshot causes no events, and the stored list is left as it was.

For an accepted snapshot, the block first sends one release event for each stored key that is no longer present. It then sends one press event for each key in the new list. After the last event it raises a one-cycle sync pulse. Events leave on a valid/ready handshake. The block accepts no new snapshot until the current frame has been fully sent.

Top module: `keyset_event_filter`

## Requirements
- R1: A snapshot is taken on a cycle where `snap_valid` and `snap_ready` are both high. Once a non-rejected snapshot is taken, `snap_ready` stays low until the frame's sync pulse has been sent. A snapshot offered while the block is busy waits and is taken later, so no frame is lost or merged.
- R2: Each entry is one byte. It counts only when bit 7 is set. Bits 6:3 hold the row and bits 2:0 hold the column. The scan code is row*8 + column, which is bits 6:0 of the entry. Entries with bit 7 clear are ignored.
- R3: When `cfg_fn_en` is high, every live entry whose code equals `cfg_fn_code` is left out of the list and sets a function-held flag. When `cfg_fn_en` is low, such an entry is reported like any other key.
- R4: While the function-held flag is set, every remaining code is increased by ROWS*COLS. With the default parameters this is 128.
- R5: A snapshot is rejected when `cfg_ghost_en` is high, the list holds at least three keys after the function key is removed, some pair of keys shares a row, and some pair shares a column. A rejected snapshot causes no events and no sync pulse, and the stored list is kept unchanged.
- R6: No snapshot is rejected when `cfg_ghost_en` is low, or when no pair of keys shares a column.
- R7: For each stored key that is absent from the new list, a release event (`ev_press`=0) is sent, in stored order. All release events come before any press event.
- R8: A press event (`ev_press`=1) is sent for every code in the new list, in entry-slot order. The new list then replaces the stored list.
- R9: A snapshot with `snap_count` equal to zero ignores its entries. It sends release events for every stored key and leaves the stored list empty.
- R10: An event moves on a cycle where `ev_valid` and `ev_ready` are both high. While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_press` and `ev_code` hold their values. `ev_valid` is never high while `snap_ready` is high.
- R11: `frame_sync` is high for exactly one cycle after the last event of each accepted frame, including a frame with no events. No event is valid in that cycle, and `snap_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ghost_en | input | 1 | Enables rejection of ghosting snapshots |
| cfg_fn_en | input | 1 | Enables function-key removal and bank shift |
| cfg_fn_code | input | 7 | Scan code of the function key |
| snap_valid | input | 1 | A snapshot is offered |
| snap_ready | output | 1 | The block can take a snapshot |
| snap_count | input | CNT_W (4) | Number of entries in the source; zero means all keys are released |
| snap_entries | input | SLOTS*8 (64) | Packed entries, slot 0 in bits 7:0 |
| ev_valid | output | 1 | An event is offered |
| ev_ready | input | 1 | Downstream takes the event |
| ev_press | output | 1 | 1 for a press event, 0 for a release event |
| ev_code | output | CODE_W (8) | Scan code of the event, including any bank shift |
| frame_sync | output | 1 | One-cycle pulse that ends an accepted frame |

## Verification
The assertions assume the following about the inputs:
- While `snap_valid` is high, the snapshot data and the configuration inputs stay fixed until the snapshot is taken.
- The configuration inputs do not change while a frame is being sent.
- `snap_count` never exceeds SLOTS.

`ev_ready` may change on any cycle. The stimulus changes configuration only when the block is idle, and holds each offered snapshot until `snap_ready` is seen high. It drives `ev_ready` in two patterns, a light one and a heavy one that stalls most cycles, so that events are held across many cycles. One snapshot is deliberately offered while the block is busy.

// File: rtl/keyset_pkg.sv
package keyset_pkg;
  localparam int ENTRY_W = 8;
  localparam int RAW_W   = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_REL, ST_PRS, ST_SYNC} emit_state_t;

  // entry byte: bit 7 live, bits 6:3 row, bits 2:0 column
  function automatic logic entry_live(input logic [ENTRY_W-1:0] e);
    return e[7];
  endfunction

  function automatic logic [RAW_W-1:0] entry_code(input logic [ENTRY_W-1:0] e);
    return {e[6:3], e[2:0]};
  endfunction

  function automatic logic [3:0] code_row(input logic [RAW_W-1:0] c);
    return c[6:3];
  endfunction

  function automatic logic [2:0] code_col(input logic [RAW_W-1:0] c);
    return c[2:0];
  endfunction

  // move a code into the alternate bank while the function key is held
  function automatic logic [RAW_W:0] bank_shift(input logic [RAW_W-1:0] c,
                                                input logic held,
                                                input int unsigned offset);
    logic [RAW_W:0] off;
    off = offset[RAW_W:0];
    return held ? ({1'b0, c} + off) : {1'b0, c};
  endfunction
endpackage

// File: rtl/kse_decode.sv
module kse_decode
  import keyset_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int NUM_KEYS = 128,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 3,
  parameter int CODE_W   = 8
) (
  input  logic [SLOTS*ENTRY_W-1:0] entries,
  input  logic [CNT_W-1:0]         count,
  input  logic                     ghost_en,
  input  logic                     fn_en,
  input  logic [RAW_W-1:0]         fn_code,
  output logic [SLOTS*CODE_W-1:0]  list,
  output logic [CNT_W-1:0]         list_cnt,
  output logic                     ghost
);
  logic [RAW_W-1:0] raw [SLOTS];
  logic [CNT_W-1:0] n;
  logic             held;
  logic             same_r, same_c;

  // compact live, non-function entries into slot order
  always_comb begin
    n    = '0;
    held = 1'b0;
    for (int k = 0; k < SLOTS; k++) raw[k] = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (entry_live(entries[i*ENTRY_W +: ENTRY_W])) begin
        if (fn_en && (entry_code(entries[i*ENTRY_W +: ENTRY_W]) == fn_code)) begin
          held = 1'b1;
        end else begin
          raw[n[IDX_W-1:0]] = entry_code(entries[i*ENTRY_W +: ENTRY_W]);
          n = n + CNT_W'(1);
        end
      end
    end
  end

  // any pair on one row, any pair on one column
  always_comb begin
    same_r = 1'b0;
    same_c = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = i + 1; j < SLOTS; j++) begin
        if (j < int'(n)) begin
          if (code_row(raw[i]) == code_row(raw[j])) same_r = 1'b1;
          if (code_col(raw[i]) == code_col(raw[j])) same_c = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_out
    assign list[g*CODE_W +: CODE_W] = CODE_W'(bank_shift(raw[g], held, NUM_KEYS));
  end

  assign list_cnt = (count == '0) ? '0 : n;
  assign ghost    = (count != '0) && ghost_en && (n >= CNT_W'(3)) && same_r && same_c;
endmodule

// File: rtl/kse_member.sv
module kse_member #(
  parameter int SLOTS  = 8,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [CODE_W-1:0]       probe,
  input  logic [SLOTS*CODE_W-1:0] list,
  input  logic [CNT_W-1:0]        cnt,
  output logic                    hit
);
  logic [SLOTS-1:0] eq;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign eq[g] = (CNT_W'(g) < cnt) && (list[g*CODE_W +: CODE_W] == probe);
  end

  assign hit = |eq;
endmodule

// File: rtl/kse_emitter.sv
module kse_emitter
  import keyset_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int CODE_W = 8,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    drop,
  input  logic [SLOTS*CODE_W-1:0] in_list,
  input  logic [CNT_W-1:0]        in_cnt,
  output logic                    busy,
  output logic                    ev_valid,
  input  logic                    ev_ready,
  output logic                    ev_press,
  output logic [CODE_W-1:0]       ev_code,
  output logic                    frame_sync
);
  emit_state_t             st;
  logic [CNT_W-1:0]        idx, prev_cnt, new_cnt;
  logic [SLOTS*CODE_W-1:0] prev_list, new_list;
  logic [CODE_W-1:0]       prev_cur, new_cur;
  logic                    kept, rel_done, prs_done;

  assign prev_cur = prev_list[int'(idx[IDX_W-1:0])*CODE_W +: CODE_W];
  assign new_cur  = new_list[int'(idx[IDX_W-1:0])*CODE_W +: CODE_W];

  kse_member #(.SLOTS(SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_keep (
    .probe(prev_cur),
    .list (new_list),
    .cnt  (new_cnt),
    .hit  (kept)
  );

  assign rel_done   = (idx >= prev_cnt);
  assign prs_done   = (idx >= new_cnt);
  assign busy       = (st != ST_IDLE);
  assign ev_valid   = ((st == ST_REL) && !rel_done && !kept) || ((st == ST_PRS) && !prs_done);
  assign ev_press   = (st == ST_PRS);
  assign ev_code    = (st == ST_PRS) ? new_cur : prev_cur;
  assign frame_sync = (st == ST_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      prev_cnt  <= '0;
      new_cnt   <= '0;
      prev_list <= '0;
      new_list  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take && !drop) begin
          new_list <= in_list;
          new_cnt  <= in_cnt;
          idx      <= '0;
          st       <= ST_REL;
        end
        ST_REL: if (rel_done) begin
          idx <= '0;
          st  <= ST_PRS;
        end else if (kept || ev_ready) begin
          idx <= idx + CNT_W'(1);
        end
        ST_PRS: if (prs_done) begin
          st <= ST_SYNC;
        end else if (ev_ready) begin
          idx <= idx + CNT_W'(1);
        end
        ST_SYNC: begin
          prev_list <= new_list;
          prev_cnt  <= new_cnt;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keyset_event_filter.sv
module keyset_event_filter
  import keyset_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int CODE_W = RAW_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_ghost_en,
  input  logic                     cfg_fn_en,
  input  logic [RAW_W-1:0]         cfg_fn_code,
  input  logic                     snap_valid,
  output logic                     snap_ready,
  input  logic [CNT_W-1:0]         snap_count,
  input  logic [SLOTS*ENTRY_W-1:0] snap_entries,
  output logic                     ev_valid,
  input  logic                     ev_ready,
  output logic                     ev_press,
  output logic [CODE_W-1:0]        ev_code,
  output logic                     frame_sync
);
  localparam int NUM_KEYS = ROWS * COLS;
  localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS*CODE_W-1:0] d_list;
  logic [CNT_W-1:0]        d_cnt;
  logic                    d_ghost;
  logic                    busy;
  logic                    snap_take;
  logic                    snap_drop;

  kse_decode #(
    .SLOTS(SLOTS), .NUM_KEYS(NUM_KEYS), .CNT_W(CNT_W), .IDX_W(IDX_W), .CODE_W(CODE_W)
  ) u_decode (
    .entries (snap_entries),
    .count   (snap_count),
    .ghost_en(cfg_ghost_en),
    .fn_en   (cfg_fn_en),
    .fn_code (cfg_fn_code),
    .list    (d_list),
    .list_cnt(d_cnt),
    .ghost   (d_ghost)
  );

  assign snap_ready = !busy;
  assign snap_take  = snap_valid && snap_ready;
  assign snap_drop  = snap_take && d_ghost;

  kse_emitter #(
    .SLOTS(SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (snap_take),
    .drop      (d_ghost),
    .in_list   (d_list),
    .in_cnt    (d_cnt),
    .busy      (busy),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .ev_press  (ev_press),
    .ev_code   (ev_code),
    .frame_sync(frame_sync)
  );
endmodule

// File: rtl/keyset_event_filter_chk.sv
module keyset_event_filter_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snap_ready,
  input logic              snap_take,
  input logic              snap_drop,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              ev_press,
  input logic [CODE_W-1:0] ev_code,
  input logic              frame_sync
);
  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_take && !snap_drop) |=> !snap_ready);  // R1
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    snap_drop |=> (!ev_valid && !frame_sync && snap_ready));  // R5
  AST_HOLD_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_code) && $stable(ev_press)));  // R10
  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ready |-> !ev_valid);  // R10
  AST_SYNC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> !ev_valid);  // R11
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (!frame_sync && snap_ready));  // R11
endmodule

bind keyset_event_filter keyset_event_filter_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .snap_ready(snap_ready),
  .snap_take (snap_take),
  .snap_drop (snap_drop),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_press  (ev_press),
  .ev_code   (ev_code),
  .frame_sync(frame_sync)
);

// File: tb/keyset_event_filter_tb_top.sv
module keyset_event_filter_tb_top;
  localparam int SLOTS = 8;
  localparam int CNT_W = 4;
  localparam int BANK  = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ghost_en = 1'b0;
  logic        cfg_fn_en = 1'b0;
  logic [6:0]  cfg_fn_code = 7'd0;
  logic        snap_valid = 1'b0;
  logic        snap_ready;
  logic [3:0]  snap_count = '0;
  logic [63:0] snap_entries = '0;
  logic        ev_valid;
  logic        ev_ready;
  logic        ev_press;
  logic [7:0]  ev_code;
  logic        frame_sync;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int exp_q[$];
  int prev_m[$];
  int frames_pending = 0;
  int ghost_drops = 0;
  int stall_mode = 0;
  int cyc = 0;
  int got;
  int want;

  always #10 clk = ~clk;

  keyset_event_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ghost_en(cfg_ghost_en), .cfg_fn_en(cfg_fn_en),
    .cfg_fn_code(cfg_fn_code), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_count(snap_count), .snap_entries(snap_entries), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_press(ev_press), .ev_code(ev_code), .frame_sync(frame_sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] key(input int row, input int col);
    return {1'b1, row[3:0], col[2:0]};
  endfunction

  // behavioural reference: builds the expected event list for an accepted snapshot
  task automatic model_accept(input logic [63:0] ents, input int cnt);
    int raw[$];
    int nw[$];
    bit held = 0;
    bit sr = 0;
    bit sc = 0;
    if (cnt != 0) begin
      for (int i = 0; i < SLOTS; i++) begin
        logic [7:0] e = ents[i*8 +: 8];
        if (e[7]) begin
          int c = int'(e[6:3]) * 8 + int'(e[2:0]);
          if (cfg_fn_en && c == int'(cfg_fn_code)) held = 1;
          else raw.push_back(c);
        end
      end
    end
    if (cfg_ghost_en && raw.size() >= 3) begin
      for (int i = 0; i < raw.size(); i++)
        for (int j = i + 1; j < raw.size(); j++) begin
          if (raw[i] % 8 == raw[j] % 8) sc = 1;
          if (raw[i] / 8 == raw[j] / 8) sr = 1;
        end
    end
    if (sr && sc) begin
      ghost_drops++;
      return;
    end
    for (int k = 0; k < raw.size(); k++) nw.push_back(held ? raw[k] + BANK : raw[k]);
    for (int p = 0; p < prev_m.size(); p++) begin
      bit found = 0;
      for (int q = 0; q < nw.size(); q++) if (nw[q] == prev_m[p]) found = 1;
      if (!found) exp_q.push_back(prev_m[p]);
    end
    for (int q = 0; q < nw.size(); q++) exp_q.push_back(256 + nw[q]);
    prev_m = nw;
    frames_pending++;
  endtask

  task automatic send(input logic [63:0] ents, input int cnt);
    @(negedge clk);
    snap_entries = ents;
    snap_count   = cnt[CNT_W-1:0];
    snap_valid   = 1'b1;
    #2;
    while (!snap_ready) begin
      @(negedge clk);
      #2;
    end
    model_accept(ents, cnt);
    @(negedge clk);
    snap_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin
      @(negedge clk);
      #3;
      n++;
    end while (!(frames_pending == 0 && snap_ready) && n < 5000);
  endtask

  // event monitor, compared every clock
  initial begin
    ev_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      ev_ready = (stall_mode != 0) ? (cyc % 6 == 0) : (cyc % 3 != 2);
      #1;
      if (rst_n && ev_valid && ev_ready) begin
        got = (ev_press ? 256 : 0) + int'(ev_code);
        if (exp_q.size() == 0) chk(0, "R7", got, -1, "unexpected event");
        else begin
          want = exp_q.pop_front();
          if (want >= 256) chk(got == want, "R8", got, want, "press event");
          else             chk(got == want, "R7", got, want, "release event");
        end
      end
      if (rst_n && frame_sync) begin
        chk(frames_pending > 0 && exp_q.size() == 0, "R11", exp_q.size() + (frames_pending > 0 ? 0 : 1000), 0,
            "sync with events pending or no frame open");
        if (frames_pending > 0) frames_pending--;
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk(snap_ready == 1'b1, "R1", int'(snap_ready), 1, "ready after reset");
    chk(ev_valid == 1'b0, "R10", int'(ev_valid), 0, "no event after reset");
    chk(frame_sync == 1'b0, "R11", int'(frame_sync), 0, "no sync after reset");

    // R2 R8: single key, then two keys
    send({56'h0, key(2, 5)}, 1);
    wait_idle();
    send({48'h0, key(10, 0), key(2, 5)}, 2);
    wait_idle();
    // R7: one key replaced
    send({48'h0, key(4, 1), key(10, 0)}, 2);
    wait_idle();
    // R2: entry with bit 7 clear is ignored
    send({48'h0, 8'h3F, key(10, 0)}, 2);
    wait_idle();

    // R5: ghost triple rejected, stored list kept
    cfg_ghost_en = 1'b1;
    send({40'h0, key(6, 1), key(1, 4), key(1, 1)}, 3);
    #3;
    chk(snap_ready == 1'b1 && ev_valid == 1'b0, "R5", int'(ev_valid), 0, "activity after rejected snapshot");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #3;
      chk(frame_sync == 1'b0 && ev_valid == 1'b0, "R5", int'(frame_sync), 0, "sync after rejected snapshot");
    end
    chk(ghost_drops == 1, "R5", ghost_drops, 1, "model drop count");
    send({56'h0, key(1, 1)}, 1);
    wait_idle();

    // R6: same triple with the check disabled, then enabled without a column pair
    cfg_ghost_en = 1'b0;
    send({40'h0, key(6, 1), key(1, 4), key(1, 1)}, 3);
    wait_idle();
    cfg_ghost_en = 1'b1;
    send({40'h0, key(6, 2), key(1, 4), key(1, 1)}, 3);
    wait_idle();
    chk(ghost_drops == 1, "R6", ghost_drops, 1, "no extra rejections");

    // R3 R4 with heavy back-pressure (R10)
    stall_mode = 1;
    cfg_fn_en = 1'b1;
    cfg_fn_code = 7'd63;
    send({48'h0, key(7, 7), key(3, 3)}, 2);
    wait_idle();
    cfg_fn_en = 1'b0;
    send({48'h0, key(7, 7), key(3, 3)}, 2);
    wait_idle();

    // R1: second snapshot offered while the first frame is still going out
    send({56'h0, key(0, 0)}, 1);
    send({56'h0, key(15, 7)}, 1);
    wait_idle();
    stall_mode = 0;

    // R9: count zero releases everything, even with live entries present
    send({56'h0, key(5, 5)}, 0);
    wait_idle();
    send({56'h0, key(5, 5)}, 0);
    wait_idle();

    chk(exp_q.size() == 0, "R8", exp_q.size(), 0, "events never sent");
    chk(frames_pending == 0, "R11", frames_pending, 0, "frames without sync");
    chk(prev_m.size() == 0, "R9", prev_m.size(), 0, "stored list after count zero");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule